// File: doc/BRIEF.md
# Dual Wiper Step and Log Adjust Unit

This unit keeps the position codes of two digitally controlled resistor wipers and applies every command that changes them. Four kinds of change exist. A direct write loads a data word. A linear step moves the code up or down by one. A logarithmic step doubles or halves the code by shifting it one bit. Each change acts either on the channel picked by a select bit or on both channels at once. All changes saturate at the ends of the code range. The left shift has two taper rules: zero becomes one, and any code in the upper half goes straight to full scale.

A serial front end decodes each command and presents it as an opcode, a channel select, a data field and a one-cycle execute strobe. A preset controller restores stored positions through per-channel load requests. An active-low write-protect input locks out every command but never blocks a load. Both wiper codes are always visible on the outputs for readback.

Top module: `wiper_adjust_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both wiper codes equal midscale (512 for 10-bit codes).
- R2: Opcode 11 with the strobe high writes cmd_data into the selected channel (cmd_sel 0 picks wiper_a, 1 picks wiper_b). The new code is visible from the cycle after the strobe.
- R3: Opcode 14 adds one to the selected channel and holds at 1023. Opcode 6 subtracts one and holds at 0.
- R4: Opcode 15 adds one to both channels and opcode 7 subtracts one from both, in the same clock cycle, with the saturation limits of R3 applied per channel.
- R5: Opcode 12 doubles the selected channel. A code of 0 becomes 1, and any code of 512 or more becomes 1023.
- R6: Opcode 4 halves the selected channel, dropping the low bit (1023, 511, 255, ...). A code of 0 stays 0.
- R7: Opcodes 13 and 5 apply the rules of R5 and R6 to both channels in the same cycle.
- R8: The step and shift opcodes (4, 5, 6, 7, 12, 13, 14, 15) give the same result whatever value cmd_data holds.
- R9: While wp_n is low, no opcode changes either wiper code.
- R10: A load request on a channel puts that channel's load code into it on the next cycle, even while wp_n is low. It takes priority over any command on that channel in the same cycle.
- R11: Opcodes 0 to 3 and 8 to 10, and any opcode presented while the strobe is low, leave both codes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Execute strobe, one cycle per command |
| cmd_op | input | 4 | Decoded opcode |
| cmd_sel | input | 1 | Channel select for single-channel opcodes |
| cmd_data | input | 10 | Data for the direct write |
| wp_n | input | 1 | Write protect, active low |
| load_req | input | 2 | Load request per channel (bit 0 for channel a, bit 1 for channel b) |
| load_code_a | input | 10 | Code loaded into channel a on a load request |
| load_code_b | input | 10 | Code loaded into channel b on a load request |
| wiper_a | output | 10 | Wiper code of channel a |
| wiper_b | output | 10 | Wiper code of channel b |

## Verification
The bench walks the left shift from zero through every power of two up to full scale and past it. A design that doubled blindly would wrap or stop at 512 instead of jumping to 1023. It also drives linear steps onto both rails, both singly and ganged, where a missing guard would wrap 1023 to 0 or 0 to 1023. It sends commands with write-protect low at the same moment as preset loads, which exposes a gate placed on the wrong path: either commands get through, or protected loads are lost. It also sets the data field to non-zero during steps and shifts, and sends the unused opcodes, to catch decode leaks that would disturb a wiper.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_INC,
    ACT_DEC,
    ACT_SHL,
    ACT_SHR
  } wiper_act_e;

  localparam logic [3:0] OP_SHR_ONE = 4'd4;
  localparam logic [3:0] OP_SHR_ALL = 4'd5;
  localparam logic [3:0] OP_DEC_ONE = 4'd6;
  localparam logic [3:0] OP_DEC_ALL = 4'd7;
  localparam logic [3:0] OP_WRITE   = 4'd11;
  localparam logic [3:0] OP_SHL_ONE = 4'd12;
  localparam logic [3:0] OP_SHL_ALL = 4'd13;
  localparam logic [3:0] OP_INC_ONE = 4'd14;
  localparam logic [3:0] OP_INC_ALL = 4'd15;

endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import wiper_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [3:0]      op_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            wp_n_i,
  output wiper_act_e      act_o [NCH]
);

  wiper_act_e kind;
  logic       gang;

  always_comb begin
    kind = ACT_NONE;
    gang = 1'b0;
    if (valid_i && wp_n_i) begin
      case (op_i)
        OP_WRITE:   kind = ACT_WRITE;
        OP_INC_ONE: kind = ACT_INC;
        OP_DEC_ONE: kind = ACT_DEC;
        OP_SHL_ONE: kind = ACT_SHL;
        OP_SHR_ONE: kind = ACT_SHR;
        OP_INC_ALL: begin kind = ACT_INC; gang = 1'b1; end
        OP_DEC_ALL: begin kind = ACT_DEC; gang = 1'b1; end
        OP_SHL_ALL: begin kind = ACT_SHL; gang = 1'b1; end
        OP_SHR_ALL: begin kind = ACT_SHR; gang = 1'b1; end
        default:    kind = ACT_NONE;
      endcase
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_route
    assign act_o[ch] = (gang || (sel_i == SELW'(ch))) ? kind : ACT_NONE;
  end

  AST_GANG_INC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wp_n_i && op_i == OP_INC_ALL) |-> (act_o[0] == ACT_INC && act_o[1] == ACT_INC)); // R4

  AST_SINGLE_ONE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_WRITE) |-> (act_o[0] == ACT_NONE || act_o[1] == ACT_NONE)); // R2

endmodule

// File: rtl/wiper_step_alu.sv
module wiper_step_alu
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] code_i,
  input  wiper_act_e   act_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] code_o
);

  localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
  localparam logic [W-1:0] CODE_MID = W'(1) << (W - 1);

  always_comb begin
    case (act_i)
      ACT_WRITE: code_o = data_i;
      ACT_INC:   code_o = (code_i == CODE_MAX) ? code_i : code_i + W'(1);
      ACT_DEC:   code_o = (code_i == '0) ? code_i : code_i - W'(1);
      ACT_SHL: begin
        if (code_i == '0)            code_o = W'(1);
        else if (code_i >= CODE_MID) code_o = CODE_MAX;
        else                         code_o = code_i << 1;
      end
      ACT_SHR:   code_o = code_i >> 1;
      default:   code_o = code_i;
    endcase
  end

endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wiper_act_e   act_i,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  input  logic [W-1:0] load_code_i,
  output logic [W-1:0] code_o
);

  localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
  localparam logic [W-1:0] CODE_MID = W'(1) << (W - 1);

  logic [W-1:0] code_q;
  logic [W-1:0] alu_code;
  logic [W-1:0] code_d;
  logic         code_en;

  wiper_step_alu #(.W(W)) u_alu (
    .code_i (code_q),
    .act_i  (act_i),
    .data_i (data_i),
    .code_o (alu_code)
  );

  always_comb begin
    code_en = load_i || (act_i != ACT_NONE);
    code_d  = load_i ? load_code_i : alu_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CODE_MID;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (code_q == $past(load_code_i))); // R10

  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_WRITE) |=> (code_q == $past(data_i))); // R2

  AST_INC_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_INC && code_q == CODE_MAX) |=> (code_q == CODE_MAX)); // R3

  AST_DEC_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_DEC && code_q == '0) |=> (code_q == '0)); // R3

  AST_SHL_UPPER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_SHL && code_q >= CODE_MID) |=> (code_q == CODE_MAX)); // R5

  AST_SHR_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_SHR) |=> (code_q == ($past(code_q) >> 1))); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_NONE) |=> $stable(code_q)); // R11

endmodule

// File: rtl/wiper_adjust_unit.sv
module wiper_adjust_unit
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic         cmd_sel,
  input  logic [W-1:0] cmd_data,
  input  logic         wp_n,
  input  logic [1:0]   load_req,
  input  logic [W-1:0] load_code_a,
  input  logic [W-1:0] load_code_b,
  output logic [W-1:0] wiper_a,
  output logic [W-1:0] wiper_b
);

  localparam int NCH  = 2;
  localparam int SELW = $clog2(NCH);

  wiper_act_e   act   [NCH];
  logic [W-1:0] ld_code [NCH];
  logic [W-1:0] code  [NCH];

  assign ld_code[0] = load_code_a;
  assign ld_code[1] = load_code_b;

  wiper_cmd_decode #(.NCH(NCH), .SELW(SELW)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (cmd_valid),
    .op_i    (cmd_op),
    .sel_i   (cmd_sel),
    .wp_n_i  (wp_n),
    .act_o   (act)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    wiper_channel #(.W(W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act[ch]),
      .data_i      (cmd_data),
      .load_i      (load_req[ch]),
      .load_code_i (ld_code[ch]),
      .code_o      (code[ch])
    );
  end

  assign wiper_a = code[0];
  assign wiper_b = code[1];

  AST_WP_LOCK_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !load_req[0]) |=> $stable(wiper_a)); // R9

  AST_WP_LOCK_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !load_req[1]) |=> $stable(wiper_b)); // R9

  AST_GANG_DEC_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wp_n && cmd_op == OP_DEC_ALL && load_req == 2'b00
     && wiper_a != '0 && wiper_b != '0)
    |=> (wiper_a == $past(wiper_a) - W'(1) && wiper_b == $past(wiper_b) - W'(1))); // R4

endmodule

// File: tb/tb_wiper_adjust_unit.sv
`timescale 1ns/1ps
module tb_wiper_adjust_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic       cmd_sel;
  logic [9:0] cmd_data;
  logic       wp_n;
  logic [1:0] load_req;
  logic [9:0] load_code_a, load_code_b;
  logic [9:0] wiper_a, wiper_b;

  int n_cmp = 0;
  int n_bad = 0;
  int ma = 512;
  int mb = 512;

  always #2.5 clk = ~clk;

  wiper_adjust_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .wp_n(wp_n), .load_req(load_req),
    .load_code_a(load_code_a), .load_code_b(load_code_b),
    .wiper_a(wiper_a), .wiper_b(wiper_b)
  );

  // kinds: 0 none, 1 write, 2 up, 3 down, 4 double, 5 halve
  function automatic int kind_of(int op);
    case (op)
      11: return 1;
      14, 15: return 2;
      6, 7: return 3;
      12, 13: return 4;
      4, 5: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit both_ch(int op);
    return (op == 15 || op == 7 || op == 13 || op == 5);
  endfunction

  function automatic int model_next(int c, int k, int d);
    int r;
    r = c;
    if (k == 1) r = d;
    else if (k == 2) r = (c < 1023) ? c + 1 : 1023;
    else if (k == 3) r = (c > 0) ? c - 1 : 0;
    else if (k == 4) begin
      if (c == 0) r = 1;
      else if (c >= 512) r = 1023;
      else r = c * 2;
    end
    else if (k == 5) r = c / 2;
    return r;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(string tag, bit v, int op, bit sel, int data,
                     bit wp, bit la, bit lb, int lca, int lcb);
    cmd_valid   = v;
    cmd_op      = op[3:0];
    cmd_sel     = sel;
    cmd_data    = data[9:0];
    wp_n        = wp;
    load_req    = {lb, la};
    load_code_a = lca[9:0];
    load_code_b = lcb[9:0];
    @(posedge clk);
    if (la) ma = lca;
    else if (v && wp && (both_ch(op) || !sel)) ma = model_next(ma, kind_of(op), data);
    if (lb) mb = lcb;
    else if (v && wp && (both_ch(op) || sel)) mb = model_next(mb, kind_of(op), data);
    @(negedge clk);
    check({tag, " ch_a"}, int'(wiper_a), ma);
    check({tag, " ch_b"}, int'(wiper_b), mb);
  endtask

  task automatic cmd(string tag, int op, bit sel, int data);
    cyc(tag, 1'b1, op, sel, data, 1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sel = 1'b0; cmd_data = '0;
    wp_n = 1'b1; load_req = '0; load_code_a = '0; load_code_b = '0;
    repeat (3) @(negedge clk);
    check("R1 reset a", int'(wiper_a), 512);
    check("R1 reset b", int'(wiper_b), 512);
    rst_n = 1'b1;
    cyc("R1 idle", 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 0);

    // R2 direct writes
    cmd("R2 write a", 11, 1'b0, 256);
    cmd("R2 write b", 11, 1'b1, 512);
    check("R2 literal a", int'(wiper_a), 256);

    // R3 single steps with saturation
    cmd("R3 set a", 11, 1'b0, 1022);
    for (int i = 0; i < 3; i++) cmd("R3 inc a", 14, 1'b0, 0);
    check("R3 top literal", int'(wiper_a), 1023);
    cmd("R3 set b", 11, 1'b1, 1);
    for (int i = 0; i < 3; i++) cmd("R3 dec b", 6, 1'b1, 0);
    check("R3 floor literal", int'(wiper_b), 0);

    // R4 ganged steps
    cmd("R4 gang inc", 15, 1'b0, 0);
    cmd("R4 gang inc", 15, 1'b1, 0);
    cmd("R4 set a", 11, 1'b0, 1);
    for (int i = 0; i < 3; i++) cmd("R4 gang dec", 7, 1'b0, 0);

    // R5 left shift from zero through the taper
    cmd("R5 zero a", 11, 1'b0, 0);
    for (int i = 0; i < 10; i++) cmd("R5 shl a", 12, 1'b0, 0);
    check("R5 512 literal", int'(wiper_a), 512);
    for (int i = 0; i < 3; i++) cmd("R5 shl a top", 12, 1'b0, 0);
    check("R5 full literal", int'(wiper_a), 1023);
    cmd("R5 set b", 11, 1'b1, 700);
    cmd("R5 shl b upper", 12, 1'b1, 0);
    cmd("R5 set b", 11, 1'b1, 511);
    cmd("R5 shl b below", 12, 1'b1, 0);

    // R6 right shift down to zero
    cmd("R6 set a", 11, 1'b0, 1023);
    cmd("R6 shr a", 4, 1'b0, 0);
    cmd("R6 shr a", 4, 1'b0, 0);
    check("R6 255 literal", int'(wiper_a), 255);
    for (int i = 0; i < 10; i++) cmd("R6 shr a", 4, 1'b0, 0);

    // R7 ganged shifts
    cmd("R7 set a", 11, 1'b0, 3);
    cmd("R7 set b", 11, 1'b1, 600);
    for (int i = 0; i < 3; i++) cmd("R7 gang shl", 13, 1'b0, 0);
    for (int i = 0; i < 4; i++) cmd("R7 gang shr", 5, 1'b1, 0);

    // R8 data field is ignored by steps and shifts
    cmd("R8 set a", 11, 1'b0, 100);
    cmd("R8 inc data", 14, 1'b0, 1023);
    cmd("R8 dec data", 6, 1'b0, 555);
    cmd("R8 shl data", 12, 1'b0, 1);
    cmd("R8 shr all data", 5, 1'b0, 1023);
    cmd("R8 inc all data", 15, 1'b0, 7);
    check("R8 literal a", int'(wiper_a), 101);

    // R9 write protect blocks every command
    cyc("R9 wp write", 1'b1, 11, 1'b0, 9, 1'b0, 1'b0, 1'b0, 0, 0);
    cyc("R9 wp inc all", 1'b1, 15, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0);
    cyc("R9 wp shl", 1'b1, 12, 1'b1, 0, 1'b0, 1'b0, 1'b0, 0, 0);
    cyc("R9 wp dec all", 1'b1, 7, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0);

    // R10 loads under protect and against commands
    cyc("R10 load a wp", 1'b1, 15, 1'b0, 0, 1'b0, 1'b1, 1'b0, 321, 0);
    check("R10 literal a", int'(wiper_a), 321);
    cyc("R10 load b wp", 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 0, 77);
    cyc("R10 load vs write", 1'b1, 11, 1'b0, 5, 1'b1, 1'b1, 1'b0, 800, 0);
    cyc("R10 load b vs gang", 1'b1, 15, 1'b0, 0, 1'b1, 1'b0, 1'b1, 0, 1000);
    cyc("R10 both loads", 1'b1, 13, 1'b0, 0, 1'b1, 1'b1, 1'b1, 12, 34);

    // R11 unused opcodes and missing strobe
    for (int op = 0; op < 11; op++)
      if (op < 4 || op > 7) begin
        cmd("R11 unused a", op, 1'b0, 999);
        cmd("R11 unused b", op, 1'b1, 999);
      end
    cyc("R11 no strobe", 1'b0, 11, 1'b0, 444, 1'b1, 1'b0, 1'b0, 0, 0);
    cyc("R11 no strobe", 1'b0, 15, 1'b1, 444, 1'b1, 1'b0, 1'b0, 0, 0);
    check("R11 literal a", int'(wiper_a), 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule